// File: doc/BRIEF.md
# Time-Division Space Switch Matrix

This block is the space stage of a digital switching fabric. It takes M parallel streams of 8-bit time slots and routes them onto N output streams through a gated crosspoint array. All streams share one frame strobe. The block keeps its own slot counter, so every input stream carries slot k in the same clock cycle. In each slot, every output takes its byte from at most one input, and the choice can differ from one slot to the next. A slot never moves in time. Slot k taken from an input leaves as slot k on the output.

Each output has its own routing table with one entry per slot. An entry holds a source index and an enable bit. Because each output stores exactly one source per slot, two inputs can never drive the same output. One input may still feed several outputs in the same slot, which gives broadcast. A configuration port writes entries into a shadow copy of the table. The shadow copy becomes live at the next frame strobe, so a frame in progress is never disturbed. The same table supports equal input and output counts (nonblocking), more inputs than outputs (concentration) and fewer inputs than outputs (expansion). In any slot, at most min(M, N) inputs are carried.

Top module: `tss_space_switch`

## Requirements
- R1: During and right after reset, every output byte is 0xFF and `out_sync` is 0. Every routing entry starts disabled.
- R2: Suppose the live entry for output j in slot k is enabled and names input i. Then the output byte j that appears one clock after the slot-k input cycle equals input i's slot-k byte. Input i occupies bits [i*8 +: 8] of `in_data`, and output j occupies bits [j*8 +: 8] of `out_data`.
- R3: The source of an output may change in every slot of a frame, following that slot's own entry.
- R4: Several outputs may select the same input in the same slot. Each of them receives the same byte.
- R5: An output whose live entry for the current slot is disabled (enable bit 0) drives 0xFF in the following cycle.
- R6: A configuration write accepted in a cycle takes effect only from the first `frame_sync` cycle strictly after that cycle. A write in the same cycle as `frame_sync` takes effect at the frame after that. Between strobes, the live table does not change.
- R7: When `frame_sync` is 1, the current slot is 0. Otherwise the slot number is the previous one plus 1, and it wraps from SLOTS-1 to 0 without a strobe. The counter starts so that the first cycle after reset is slot 0.
- R8: `out_sync` equals `frame_sync` delayed by one clock. It marks the output cycle that carries slot 0.
- R9: A write is ignored, and leaves the table unchanged, if any of these holds: `cfg_out` >= N_OUT, `cfg_slot` >= SLOTS, or `cfg_src` >= N_IN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Marks the cycle that carries slot 0 on all inputs |
| in_data | input | N_IN*DW | Input slot bytes, input i at [i*DW +: DW] |
| cfg_we | input | 1 | Writes one routing entry |
| cfg_out | input | OUT_W | Output index of the entry |
| cfg_slot | input | SLW | Slot index of the entry |
| cfg_src | input | SRC_W | Source input index |
| cfg_en | input | 1 | Enable bit of the entry |
| out_sync | output | 1 | Frame marker aligned with the output bytes |
| out_data | output | N_OUT*DW | Output slot bytes, output j at [j*DW +: DW] |

## Verification
The bench builds the block with five inputs, three outputs and six slots. The array therefore concentrates, and none of the counts is a power of two. With these values the index fields have spare codes: source 5 to 7, slot 6 and 7, and output 3. These codes let the bench exercise the out-of-range write rejection. A scoreboard computes the expected bytes from its own copy of the routing table and slot counter. The stimulus includes free-running frames with no strobe, a strobe that arrives mid-count, writes made mid-frame and writes made in the strobe cycle itself, broadcast, and disabled entries.

// File: rtl/tss_pkg.sv
package tss_pkg;

  // index width for a count, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // slot that follows prev in a frame of slots cycles
  function automatic int slot_after(input int prev, input int slots);
    return (prev + 1 >= slots) ? 0 : prev + 1;
  endfunction

  // a configuration write is accepted only with all indices in range
  function automatic bit cfg_legal(input int o, input int s, input int src,
                                   input int n_out, input int slots, input int n_in);
    return (o < n_out) && (s < slots) && (src < n_in);
  endfunction

  // flat table position of (output, slot)
  function automatic int entry_pos(input int o, input int s, input int slots);
    return o * slots + s;
  endfunction

endpackage

// File: rtl/tss_slot_ctr.sv
module tss_slot_ctr import tss_pkg::*; #(
  parameter int SLOTS = 8,
  parameter int SLW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_sync,
  output logic [SLW-1:0] cur_slot
);

  logic [SLW-1:0] cnt_q;

  assign cur_slot = frame_sync ? '0 : SLW'(slot_after(int'(cnt_q), SLOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= SLW'(SLOTS - 1);
    else        cnt_q <= cur_slot;
  end

  // R7: slot number always stays inside the frame
  assert_slot_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_slot) < SLOTS);

endmodule

// File: rtl/tss_ctrl_mem.sv
module tss_ctrl_mem import tss_pkg::*; #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int SLOTS = 8,
  parameter int SRC_W = 2,
  parameter int SLW   = 3,
  parameter int OUT_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_sync,
  input  logic [SLW-1:0]              rd_slot,
  input  logic                        cfg_we,
  input  logic [OUT_W-1:0]            cfg_out,
  input  logic [SLW-1:0]              cfg_slot,
  input  logic [SRC_W-1:0]            cfg_src,
  input  logic                        cfg_en,
  output logic [N_OUT-1:0][SRC_W-1:0] sel_src,
  output logic [N_OUT-1:0]            sel_vld
);

  localparam int ENT = N_OUT * SLOTS;
  localparam int EW  = SRC_W + 1;
  localparam int IW  = idx_w(ENT);

  logic [ENT-1:0][EW-1:0] shd_q;
  logic [ENT-1:0][EW-1:0] act_q;
  logic                   wr_ok;
  logic [IW-1:0]          wr_idx;

  assign wr_ok  = cfg_we && cfg_legal(int'(cfg_out), int'(cfg_slot), int'(cfg_src),
                                      N_OUT, SLOTS, N_IN);
  assign wr_idx = IW'(entry_pos(int'(cfg_out), int'(cfg_slot), SLOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (frame_sync) act_q <= shd_q;
      if (wr_ok)      shd_q[wr_idx] <= {cfg_en, cfg_src};
    end
  end

  // the strobe cycle reads the copy that is being committed
  for (genvar j = 0; j < N_OUT; j++) begin : g_rd
    logic [IW-1:0] rd_idx;
    logic [EW-1:0] ent;
    assign rd_idx     = IW'(entry_pos(j, int'(rd_slot), SLOTS));
    assign ent        = frame_sync ? shd_q[rd_idx] : act_q[rd_idx];
    assign sel_src[j] = ent[SRC_W-1:0];
    assign sel_vld[j] = ent[SRC_W];
  end

  // R6: live table only changes at a frame strobe
  assert_live_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(act_q));

  // R9: rejected writes leave the shadow table alone
  assert_bad_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_ok) |=> $stable(shd_q));

endmodule

// File: rtl/tss_xpoint_col.sv
module tss_xpoint_col #(
  parameter int N_IN  = 4,
  parameter int DW    = 8,
  parameter int SRC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN*DW-1:0] in_data,
  input  logic [SRC_W-1:0]  src,
  input  logic              vld,
  output logic [DW-1:0]     q
);

  logic [N_IN-1:0] gate;
  logic [DW-1:0]   acc;
  logic [DW-1:0]   nxt;
  logic [DW-1:0]   sel_byte;

  // one enable gate per crosspoint on this vertical
  for (genvar i = 0; i < N_IN; i++) begin : g_gate
    assign gate[i] = vld && (src == SRC_W'(i));
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < N_IN; i++)
      if (gate[i]) acc = acc | in_data[i*DW +: DW];
    nxt = (|gate) ? acc : {DW{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= {DW{1'b1}};
    else        q <= nxt;
  end

  assign sel_byte = in_data[int'(src)*DW +: DW];

  // R5: a disabled entry yields the idle byte
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> q == {DW{1'b1}});

  // R2: an enabled entry forwards the chosen input one clock later
  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> q == $past(sel_byte));

endmodule

// File: rtl/tss_space_switch.sv
module tss_space_switch import tss_pkg::*; #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int SLOTS = 8,
  parameter int DW    = 8,
  localparam int SRC_W = idx_w(N_IN),
  localparam int SLW   = idx_w(SLOTS),
  localparam int OUT_W = idx_w(N_OUT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_sync,
  input  logic [N_IN*DW-1:0]  in_data,
  input  logic                cfg_we,
  input  logic [OUT_W-1:0]    cfg_out,
  input  logic [SLW-1:0]      cfg_slot,
  input  logic [SRC_W-1:0]    cfg_src,
  input  logic                cfg_en,
  output logic                out_sync,
  output logic [N_OUT*DW-1:0] out_data
);

  logic [SLW-1:0]              cur_slot;
  logic [N_OUT-1:0][SRC_W-1:0] sel_src;
  logic [N_OUT-1:0]            sel_vld;

  tss_slot_ctr #(.SLOTS(SLOTS), .SLW(SLW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .cur_slot(cur_slot)
  );

  tss_ctrl_mem #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS),
                 .SRC_W(SRC_W), .SLW(SLW), .OUT_W(OUT_W)) u_cm (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rd_slot(cur_slot),
    .cfg_we(cfg_we), .cfg_out(cfg_out), .cfg_slot(cfg_slot),
    .cfg_src(cfg_src), .cfg_en(cfg_en), .sel_src(sel_src), .sel_vld(sel_vld)
  );

  for (genvar j = 0; j < N_OUT; j++) begin : g_col
    tss_xpoint_col #(.N_IN(N_IN), .DW(DW), .SRC_W(SRC_W)) u_col (
      .clk(clk), .rst_n(rst_n), .in_data(in_data),
      .src(sel_src[j]), .vld(sel_vld[j]), .q(out_data[j*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_sync <= 1'b0;
    else        out_sync <= frame_sync;
  end

  // R8: frame marker follows the strobe by one clock
  assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> out_sync);
  assert_sync_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> !out_sync);

endmodule

// File: tb/sim_tss_space_switch.sv
module sim_tss_space_switch;
  localparam int CLK_P = 10;
  localparam int M = 5, N = 3, S = 6, DW = 8;
  localparam int SRC_W = 3, SLW = 3, OUT_W = 2;

  logic clk = 1'b0, rst_n = 1'b0, frame_sync = 1'b0;
  logic [M*DW-1:0] in_data = '0;
  logic cfg_we = 1'b0, cfg_en = 1'b0;
  logic [OUT_W-1:0] cfg_out = '0;
  logic [SLW-1:0] cfg_slot = '0;
  logic [SRC_W-1:0] cfg_src = '0;
  logic out_sync;
  logic [N*DW-1:0] out_data;

  int checks = 0, fails = 0;
  int mslot = S - 1, frame_no = 0;
  int shd_src[N][S], act_src[N][S];
  bit shd_en[N][S], act_en[N][S];
  logic [N*DW:0] exp_q[$];
  string tag_q[$];

  tss_space_switch #(.N_IN(M), .N_OUT(N), .SLOTS(S), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_out(cfg_out), .cfg_slot(cfg_slot), .cfg_src(cfg_src),
    .cfg_en(cfg_en), .out_sync(out_sync), .out_data(out_data));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] pat(int f, int sl, int i);
    return 8'((f * 29 + sl * 7 + i * 3 + 5) & 8'h7F);
  endfunction

  // compare what the design produced for the previous cycle, then drive the next
  task automatic step(input bit sync, input string tag);
    logic [N*DW:0] e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (out_sync !== e[N*DW]) begin
        fails++;
        $display("FAIL R8 out_sync act=%0b exp=%0b", out_sync, e[N*DW]);
      end
      for (int j = 0; j < N; j++) begin
        checks++;
        if (out_data[j*DW +: DW] !== e[j*DW +: DW]) begin
          fails++;
          $display("FAIL %s out%0d act=%02h exp=%02h", t, j,
                   out_data[j*DW +: DW], e[j*DW +: DW]);
        end
      end
    end
    if (sync) begin
      mslot = 0;
      frame_no++;
      act_src = shd_src;
      act_en  = shd_en;
    end else begin
      mslot = (mslot + 1 >= S) ? 0 : mslot + 1;
    end
    for (int i = 0; i < M; i++) in_data[i*DW +: DW] = pat(frame_no, mslot, i);
    e[N*DW] = sync;
    for (int j = 0; j < N; j++)
      e[j*DW +: DW] = act_en[j][mslot] ? pat(frame_no, mslot, act_src[j][mslot]) : 8'hFF;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    frame_sync = sync;
    if (cfg_we && int'(cfg_out) < N && int'(cfg_slot) < S && int'(cfg_src) < M) begin
      shd_src[cfg_out][cfg_slot] = int'(cfg_src);
      shd_en[cfg_out][cfg_slot]  = cfg_en;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_step(input int o, input int sl, input int src, input bit en,
                          input bit sync, input string tag);
    cfg_we   = 1'b1;
    cfg_out  = OUT_W'(o);
    cfg_slot = SLW'(sl);
    cfg_src  = SRC_W'(src);
    cfg_en   = en;
    step(sync, tag);
  endtask

  task automatic run_frame(input string tag);
    step(1'b1, tag);
    for (int k = 1; k < S; k++) step(1'b0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int j = 0; j < N; j++)
      for (int k = 0; k < S; k++) begin
        shd_src[j][k] = 0; act_src[j][k] = 0;
        shd_en[j][k] = 0;  act_en[j][k] = 0;
      end
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_data !== {N*DW{1'b1}} || out_sync !== 1'b0) begin
      fails++;
      $display("FAIL R1 act=%h/%0b exp=%h/0", out_data, out_sync, {N*DW{1'b1}});
    end
    rst_n = 1'b1;
    // R5/R7: free-running with all entries disabled
    step(1'b0, "R7");
    run_frame("R5");
    // writes land in the shadow copy only (R6)
    cfg_step(0, 0, 4, 1, 0, "R6");
    cfg_step(0, 1, 0, 1, 0, "R6");
    cfg_step(0, 2, 1, 1, 0, "R6");
    cfg_step(0, 3, 2, 1, 0, "R6");
    cfg_step(1, 0, 4, 1, 0, "R6");
    cfg_step(1, 2, 3, 1, 0, "R6");
    cfg_step(2, 1, 0, 1, 0, "R6");
    cfg_step(2, 5, 4, 1, 0, "R6");
    // R2/R3/R4: routed frames, per-slot change and broadcast
    run_frame("R2");
    run_frame("R3");
    // R6: mid-frame write is deferred
    step(1'b1, "R6");
    cfg_step(0, 4, 3, 1, 0, "R6");
    for (int k = 2; k < S; k++) step(1'b0, "R6");
    run_frame("R6");
    // R5: disabling an entry
    cfg_step(0, 0, 0, 0, 1, "R5");
    for (int k = 1; k < S; k++) step(1'b0, "R5");
    run_frame("R5");
    // R9: out-of-range writes
    cfg_step(0, 1, 5, 1, 1, "R9");
    cfg_step(0, 6, 1, 1, 0, "R9");
    cfg_step(3, 1, 2, 1, 0, "R9");
    cfg_step(1, 2, 7, 0, 0, "R9");
    cfg_step(2, 7, 0, 0, 0, "R9");
    step(1'b0, "R9");
    run_frame("R9");
    // R7: free-run across wraps, then a strobe arriving mid-count
    for (int k = 0; k < 2 * S + 3; k++) step(1'b0, "R7");
    run_frame("R7");
    // R6: write in the strobe cycle waits one more frame
    cfg_step(2, 0, 2, 1, 1, "R6");
    for (int k = 1; k < S; k++) step(1'b0, "R6");
    run_frame("R6");
    step(1'b0, "R2");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule